// File: doc/BRIEF.md
# Clock-synchronous serial shift transmitter

This block sends words out of a single data pin one bit at a time. It does not generate the bit clock. It follows a bit clock that an external master supplies. That clock is taken from one of several nearby pad inputs, or from the pin's own software output bit. A 4-bit selector picks the source and can invert it, so the block can shift on the falling edge of the master's clock instead of the rising edge. The selected clock is synchronized into the system clock domain. Each rising edge of the selected clock then advances the shifter by one bit, least significant bit first, after a fixed latency.

Software places a word and its length into a holding register with a one-cycle write strobe. A buffer-empty flag tells software when that word has moved into the shifter, so the next word can be queued early. Words then follow one another with no idle bit between them. When the shifter has nothing to send, the data pin keeps the last bit it drove, and further clock edges are ignored.

Top module: `sclk_shift_tx`

## Requirements
- R1: After reset, `txOut` is 0 and `bufEmpty` is 1.
- R2: `wrLen` holds the word length minus one. A value of 0 sends exactly 1 bit and 31 sends exactly 32 bits. The first qualifying edge after the last bit, with nothing queued, leaves `txOut` unchanged.
- R3: The selected clock rises (after optional inversion) and is first seen high at system clock edge P1. `txOut` then takes its new value at edge P4 and is unchanged after P3.
- R4: The bits of a word appear on `txOut` in order from bit 0 upward, one bit per qualifying edge.
- R5: `clkSel[3]` = 1 inverts the clock source. `clkSel[2:0]` picks the source as follows: 0 is `nearPins[3]` (this pin). 1, 2 and 3 are `nearPins[4]`, `nearPins[5]` and `nearPins[6]` (+1 to +3). 4 is `localOut`. 5, 6 and 7 are `nearPins[0]`, `nearPins[1]` and `nearPins[2]` (-3 to -1).
- R6: A cycle with `wrEn` = 1 stores `wrData`/`wrLen` as the pending word and drives `bufEmpty` to 0 from the next cycle. A second write before transfer replaces the pending word.
- R7: The first qualifying edge after a write moves the pending word into the shifter. On the same system clock edge, bit 0 appears on `txOut` and `bufEmpty` returns to 1.
- R8: If a word is pending when the last bit of the current word has been sent, the next qualifying edge presents the pending word's bit 0, with no idle edge in between.
- R9: While nothing is being shifted and nothing is pending, qualifying edges leave `txOut` unchanged.
- R10: A write can fall in the same cycle as a transfer. The shifter then takes the older pending word, the new word becomes pending, and `bufEmpty` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nearPins | input | 7 | Pad inputs for pins -3..+3; index 3 is this pin |
| localOut | input | 1 | Software output bit of this pin |
| clkSel | input | 4 | Clock source select; bit 3 inverts |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 32 | Word to send |
| wrLen | input | 5 | Word length minus one |
| txOut | output | 1 | Serial data output |
| bufEmpty | output | 1 | High when no word is pending |

## Verification
The delicate case is a software write that lands in the same system cycle as the holding register moves into the shifter on a clock edge. The bench provokes it by raising `wrEn` exactly in the cycle before the fourth system edge of a bit-clock rise. It then judges the result in three ways. The older word's bit 0 must appear on that edge. `bufEmpty` must stay low. The newer word must follow the older one without a gap. Sweeps over every word length and every selector code, with the unselected sources toggling in anti-phase, make wrong selections and wrong latencies visible.

// File: rtl/sclk_tx_pkg.sv
package sclk_tx_pkg;
  // Reach of the clock source selector on each side of this pin
  localparam int NEAR_SPAN = 3;
  localparam int NEAR_W    = 2 * NEAR_SPAN + 1;
  // Source codes: this pin, +1..+SPAN, own output, -SPAN..-1
  localparam int CAND_N    = 2 * NEAR_SPAN + 2;
  localparam int CODE_W    = $clog2(CAND_N);
  localparam int SEL_W     = CODE_W + 1;
  localparam int OWN_CODE  = NEAR_SPAN + 1;

  typedef struct packed {
    logic loadShift;  // move pending word into shifter, present its bit 0
    logic shiftOn;    // present next bit of the current word
  } txStrobeT;
endpackage

// File: rtl/sclk_tx_clksel.sv
module sclk_tx_clksel
  import sclk_tx_pkg::*;
(
  input  logic [NEAR_W-1:0] nearPins,
  input  logic              localOut,
  input  logic [SEL_W-1:0]  clkSel,
  output logic              selClk
);
  logic [CAND_N-1:0] cand;

  assign cand[0]        = nearPins[NEAR_SPAN];
  assign cand[OWN_CODE] = localOut;

  generate
    for (genvar k = 1; k <= NEAR_SPAN; k++) begin : g_reach
      assign cand[k]            = nearPins[NEAR_SPAN + k];
      assign cand[OWN_CODE + k] = nearPins[k - 1];
    end
  endgenerate

  assign selClk = cand[clkSel[CODE_W-1:0]] ^ clkSel[SEL_W-1];
endmodule

// File: rtl/sclk_tx_ctrl.sv
module sclk_tx_ctrl
  import sclk_tx_pkg::*;
#(
  parameter int LEN_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selClk,
  input  logic             wrEn,
  input  logic [LEN_W-1:0] holdLen,
  output txStrobeT         stb,
  output logic             bufEmpty
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   edgeQ;
  logic                   busy;
  logic                   holdFull;
  logic [LEN_W-1:0]       remain;

  // Synchronizer, previous-sample register and registered edge flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
      edgeQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], selClk};
      prevQ <= syncQ[SYNC_STAGES-1];
      edgeQ <= syncQ[SYNC_STAGES-1] & ~prevQ;
    end
  end

  always_comb begin
    stb           = '0;
    stb.loadShift = edgeQ && holdFull && (!busy || remain == '0);
    stb.shiftOn   = edgeQ && busy && remain != '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (stb.loadShift) begin
      busy   <= 1'b1;
      remain <= holdLen;
    end else if (stb.shiftOn) begin
      remain <= remain - LEN_W'(1);
    end else if (edgeQ && busy) begin
      busy   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdFull <= 1'b0;
    else if (wrEn)          holdFull <= 1'b1;
    else if (stb.loadShift) holdFull <= 1'b0;
  end

  assign bufEmpty = ~holdFull;

  // R3: an edge is only flagged after the selected clock was seen high
  a_r3_edge_from_high_input: assert property (@(posedge clk) disable iff (!rstN)
    edgeQ |-> $past(selClk, SYNC_STAGES + 1));

  // R6: a write always leaves a word pending
  a_r6_write_fills: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !bufEmpty);

  // R7: the empty flag only returns through a transfer
  a_r7_empty_on_transfer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> $past(stb.loadShift));

  // R8: a pending word follows the last bit without a gap
  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (edgeQ && busy && remain == '0 && !bufEmpty) |-> stb.loadShift);

  // R10: coincident write and transfer keep the buffer full
  a_r10_coincident_keeps_full: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadShift && wrEn) |=> !bufEmpty);
endmodule

// File: rtl/sclk_tx_dpath.sv
module sclk_tx_dpath
  import sclk_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LEN_W-1:0]  wrLen,
  input  txStrobeT          stb,
  output logic [LEN_W-1:0]  holdLen,
  output logic              txOut
);
  logic [WORD_W-1:0] holdWord;
  logic [WORD_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      holdLen  <= '0;
    end else if (wrEn) begin
      holdWord <= wrData;
      holdLen  <= wrLen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      txOut <= 1'b0;
    end else if (stb.loadShift) begin
      txOut <= holdWord[0];
      shReg <= holdWord >> 1;
    end else if (stb.shiftOn) begin
      txOut <= shReg[0];
      shReg <= shReg >> 1;
    end
  end

  // R8: the two control strobes never coincide
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadShift, stb.shiftOn}));

  // R9: without a strobe the output line holds
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadShift || stb.shiftOn) |=> $stable(txOut));
endmodule

// File: rtl/sclk_shift_tx.sv
module sclk_shift_tx
  import sclk_tx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NEAR_W-1:0] nearPins,
  input  logic              localOut,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LEN_W-1:0]  wrLen,
  output logic              txOut,
  output logic              bufEmpty
);
  logic             selClk;
  txStrobeT         stb;
  logic [LEN_W-1:0] holdLen;

  sclk_tx_clksel i_clksel (
    .nearPins (nearPins),
    .localOut (localOut),
    .clkSel   (clkSel),
    .selClk   (selClk)
  );

  sclk_tx_ctrl #(.LEN_W(LEN_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .selClk   (selClk),
    .wrEn     (wrEn),
    .holdLen  (holdLen),
    .stb      (stb),
    .bufEmpty (bufEmpty)
  );

  sclk_tx_dpath #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .wrLen   (wrLen),
    .stb     (stb),
    .holdLen (holdLen),
    .txOut   (txOut)
  );
endmodule

// File: tb/test_sclk_shift_tx.sv
module test_sclk_shift_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  nearPins = '0;
  logic        localOut = 1'b0;
  logic [3:0]  clkSel = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [4:0]  wrLen = '0;
  logic        txOut;
  logic        bufEmpty;

  int total = 0;
  int bad = 0;
  logic prevOut = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  sclk_shift_tx i_sclk_shift_tx (
    .clk(clk), .rstN(rstN), .nearPins(nearPins), .localOut(localOut),
    .clkSel(clkSel), .wrEn(wrEn), .wrData(wrData), .wrLen(wrLen),
    .txOut(txOut), .bufEmpty(bufEmpty)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive the effective clock level; all unselected sources go the other way
  task automatic driveEff(bit lvl);
    logic raw;
    int code;
    raw = lvl ^ clkSel[3];
    code = int'(clkSel[2:0]);
    nearPins = {7{~raw}};
    localOut = ~raw;
    if (code == 4)      localOut = raw;
    else if (code < 4)  nearPins[3 + code] = raw;
    else                nearPins[code - 5] = raw;
  endtask

  task automatic writeWord(logic [31:0] w, logic [4:0] len);
    wrEn = 1'b1; wrData = w; wrLen = len;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    chk("R6 bufEmpty after write", 32'(bufEmpty), 32'd0);
  endtask

  // One bit-clock period; starts and ends at a falling system edge
  task automatic edgeBit(bit expBit, string req, bit expEmpty,
                         bit coWr, logic [31:0] w, logic [4:0] len);
    driveEff(1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 no change before latency", 32'(txOut), 32'(prevOut));
    if (coWr) begin
      wrEn = 1'b1; wrData = w; wrLen = len;
    end
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    chk(req, 32'(txOut), 32'(expBit));
    chk({req, " bufEmpty"}, 32'(bufEmpty), 32'(expEmpty));
    prevOut = expBit;
    repeat (2) @(posedge clk);
    @(negedge clk);
    driveEff(1'b0);
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b, w;
    driveEff(1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 txOut reset", 32'(txOut), 32'd0);
    chk("R1 bufEmpty reset", 32'(bufEmpty), 32'd1);
    // R9: an edge with nothing loaded is ignored
    edgeBit(1'b0, "R9 idle edge", 1'b1, 1'b0, '0, '0);

    // R4 and R2: sweep every word length, LSB first, exact bit count
    for (int n = 1; n <= 32; n++) begin
      w = (32'h9E3779B9 * n) ^ 32'h5A5A0F0F;
      writeWord(w, 5'(n - 1));
      for (int i = 0; i < n; i++)
        edgeBit(w[i], (i == 0) ? "R7 first bit" : "R4 bit order", 1'b1, 1'b0, '0, '0);
      edgeBit(prevOut, "R2 length end", 1'b1, 1'b0, '0, '0);
    end

    // R6: a second write replaces the pending word
    a = 32'h0000_00F0; b = 32'h0000_0035;
    writeWord(a, 5'd7);
    writeWord(b, 5'd7);
    for (int i = 0; i < 8; i++)
      edgeBit(b[i], "R6 replaced word", 1'b1, 1'b0, '0, '0);
    edgeBit(prevOut, "R9 hold after word", 1'b1, 1'b0, '0, '0);

    // R8: back-to-back words with no gap
    a = 32'h0000_002D; b = 32'h0000_000A;
    writeWord(a, 5'd5);
    edgeBit(a[0], "R7 first bit", 1'b1, 1'b0, '0, '0);
    writeWord(b, 5'd3);
    for (int i = 1; i < 6; i++)
      edgeBit(a[i], "R8 first word", 1'b0, 1'b0, '0, '0);
    for (int i = 0; i < 4; i++)
      edgeBit(b[i], "R8 second word", 1'b1, 1'b0, '0, '0);
    edgeBit(prevOut, "R9 hold after pair", 1'b1, 1'b0, '0, '0);

    // R10: write in the same cycle as a transfer
    a = 32'h0000_0009; b = 32'h0000_0006;
    writeWord(a, 5'd3);
    edgeBit(a[0], "R10 older word first", 1'b0, 1'b1, b, 5'd3);
    for (int i = 1; i < 4; i++)
      edgeBit(a[i], "R10 older word", 1'b0, 1'b0, '0, '0);
    for (int i = 0; i < 4; i++)
      edgeBit(b[i], "R10 newer word", 1'b1, 1'b0, '0, '0);
    edgeBit(prevOut, "R9 hold after R10", 1'b1, 1'b0, '0, '0);

    // R5: every selector code, with and without inversion
    for (int s = 0; s < 16; s++) begin
      clkSel = 4'(s);
      driveEff(1'b0);
      repeat (6) @(posedge clk);
      @(negedge clk);
      w = 32'((s * 7) ^ 32'hA);
      writeWord(w, 5'd3);
      for (int i = 0; i < 4; i++)
        edgeBit(w[i], "R5 selector", 1'b1, 1'b0, '0, '0);
      edgeBit(prevOut, "R5 selector idle", 1'b1, 1'b0, '0, '0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule